// File: doc/BRIEF.md
# Synchronous Burst Memory with Dual Address Strobes

This block is a single-port synchronous memory built from two 9-bit byte lanes, giving an 18-bit data word. Each rising clock edge samples a chip select, two address strobes, a burst-continue input, per-lane write strobes, the address and the write data. One strobe is meant for a processor and the other for a memory controller. From these inputs the block decides what the cycle does. It can end the current access (deselect), start a four-beat burst at the presented address, step to the next address of the burst, or stay on the current address as a wait state. Writes update only the lanes whose strobe is active.

A small controller state machine keeps the kind of the last accepted cycle in one of three states:
- `ST_IDLE`: no burst is open.
- `ST_READ`: the last cycle was a read.
- `ST_WRITE`: the last cycle was a write.

The transitions are as follows. A deselect returns the machine to `ST_IDLE`. A start, step or hold cycle moves it to `ST_READ` or `ST_WRITE`, depending on the write strobes. A cycle with no strobe while in `ST_IDLE` leaves it in `ST_IDLE`.

Read data is registered, so it is valid one clock after the edge that selected the address. The output enable is not clocked: it gates the bus-drive flag directly.

The burst counter uses the two lowest address bits. The beat address is the start value XOR the beat count, so a burst stays inside its aligned group of four words and wraps within that group.

Top module: `burst_sram`

## Requirements
- R1: After reset, no burst is open and `dq_oe` is 0. While no burst is open, a cycle with both strobes high writes nothing, drives nothing and leaves the state idle.
- R2: On an edge where `ce_n` is 1 and either strobe is low, the block deselects. No burst is open afterwards and `dq_oe` is 0.
- R3: On an edge where `ce_n` is 0 and `adsp_n` is 0, a read burst starts at `addr`, whatever `bwe_n` is. The word at `addr` appears on `dq_out` one clock later.
- R4: On an edge where `ce_n` is 0, `adsp_n` is 1 and `adsc_n` is 0, a burst starts at `addr`. It is a write when any bit of `bwe_n` is 0 and a read when `bwe_n` is 2'b11.
- R5: On an edge where both strobes are 1, a burst is open and `adv_n` is 0, the address steps. Beat k of a burst that started at low bits s uses low bits s XOR k, with k counting 0,1,2,3,0 and the upper address bits unchanged.
- R6: On an edge where both strobes are 1, a burst is open and `adv_n` is 1, the address does not change. The cycle is a write or a read according to `bwe_n`.
- R7: `dq_oe` is 1 only while `oe_n` is 0 and the last accepted cycle was a read. `dq_oe` follows `oe_n` without waiting for a clock edge.
- R8: After a write cycle or a deselect, `dq_oe` stays 0 whatever `oe_n` is.
- R9: `bwe_n[0]` = 0 writes `dq_in[8:0]` and `bwe_n[1]` = 0 writes `dq_in[17:9]`. A lane whose strobe is 1 keeps its old contents.
- R10: During step and hold cycles, `ce_n` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of state and burst counter |
| ce_n | input | 1 | Active-low chip select, sampled on the edge |
| adsp_n | input | 1 | Processor-side address strobe, active low; a burst it starts is always a read |
| adsc_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst continue, active low; 1 holds the address |
| bwe_n | input | 2 | Active-low byte-lane write strobes (bit 0 = lower lane) |
| oe_n | input | 1 | Asynchronous active-low output enable |
| addr | input | AW | Word address, sampled when a burst starts |
| dq_in | input | 18 | Write data |
| dq_out | output | 18 | Registered read data |
| dq_oe | output | 1 | Bus drive enable; 0 means the bus is high impedance |

## Verification
The bench first writes a full four-beat burst through the controller strobe, starting at an odd low address. It then reads the burst back through the processor strobe with the write strobes held active; this separates the interleaved order from a linear one and shows that the write strobes are ignored on that strobe. Hold cycles inserted between steps, and a fifth step that wraps, show whether the counter holds and wraps correctly. Single-lane writes show whether the lanes are independent. A step attempted after a deselect would corrupt a word that is read back later, so the read-back shows whether such a step is ignored. Toggling the output enable between edges shows whether the bus-drive flag follows it without a clock.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
    localparam int LANES      = 2;
    localparam int LANE_W     = 9;
    localparam int WORD_W     = LANES * LANE_W;
    localparam int BURST_BITS = 2;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_DESEL,
        OP_START,
        OP_ADV,
        OP_HOLD
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE
    } st_e;
endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
    import burst_sram_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_n,
    input  logic             adsp_n,
    input  logic             adsc_n,
    input  logic             adv_n,
    input  logic [LANES-1:0] bwe_n,
    output op_e              op,
    output logic [LANES-1:0] lane_we,
    output logic             rd_en,
    output st_e              state
);
    logic wr_req;
    logic busy_cyc;
    st_e  state_nx;

    // cycle decode: the processor strobe has priority and never writes
    always_comb begin
        op     = OP_NONE;
        wr_req = 1'b0;
        if (!adsp_n) begin
            op = ce_n ? OP_DESEL : OP_START;
        end else if (!adsc_n) begin
            op     = ce_n ? OP_DESEL : OP_START;
            wr_req = !ce_n && !(&bwe_n);
        end else if (state != ST_IDLE) begin
            op     = adv_n ? OP_HOLD : OP_ADV;
            wr_req = !(&bwe_n);
        end
    end

    always_comb begin
        state_nx = state;
        unique case (op)
            OP_DESEL:                   state_nx = ST_IDLE;
            OP_START, OP_ADV, OP_HOLD:  state_nx = wr_req ? ST_WRITE : ST_READ;
            OP_NONE:                    state_nx = state;
            default:                    state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // outputs toward datapath
    always_comb begin
        busy_cyc = (op == OP_START) || (op == OP_ADV) || (op == OP_HOLD);
        lane_we  = (busy_cyc && wr_req) ? ~bwe_n : '0;
        rd_en    = busy_cyc && !wr_req;
    end
endmodule

// File: rtl/burst_addr.sv
module burst_addr
    import burst_sram_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  op_e           op,
    input  logic [AW-1:0] ext_addr,
    output logic [AW-1:0] cyc_addr,
    output logic [AW-1:0] cur_addr
);
    localparam int HI_W = AW - BURST_BITS;

    logic [HI_W-1:0]       base_q;
    logic [BURST_BITS-1:0] start_q;
    logic [BURST_BITS-1:0] cnt_q;
    logic [BURST_BITS-1:0] cnt_inc;

    assign cnt_inc  = BURST_BITS'(cnt_q + 1'b1);
    assign cur_addr = {base_q, start_q ^ cnt_q};

    always_comb begin
        unique case (op)
            OP_START: cyc_addr = ext_addr;
            OP_ADV:   cyc_addr = {base_q, start_q ^ cnt_inc};
            default:  cyc_addr = cur_addr;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q  <= '0;
            start_q <= '0;
            cnt_q   <= '0;
        end else if (op == OP_START) begin
            base_q  <= ext_addr[AW-1:BURST_BITS];
            start_q <= ext_addr[BURST_BITS-1:0];
            cnt_q   <= '0;
        end else if (op == OP_ADV) begin
            cnt_q   <= cnt_inc;
        end
    end
endmodule

// File: rtl/lane_array.sv
module lane_array
    import burst_sram_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic              clk,
    input  logic [AW-1:0]     addr,
    input  logic [LANES-1:0]  lane_we,
    input  logic              rd_en,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] rd_q;

        always_ff @(posedge clk) begin
            if (lane_we[g]) mem[addr] <= wdata[g*LANE_W +: LANE_W];
            if (rd_en)      rd_q      <= mem[addr];
        end

        assign rdata[g*LANE_W +: LANE_W] = rd_q;
    end
endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import burst_sram_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              adsp_n,
    input  logic              adsc_n,
    input  logic              adv_n,
    input  logic [LANES-1:0]  bwe_n,
    input  logic              oe_n,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] dq_in,
    output logic [WORD_W-1:0] dq_out,
    output logic              dq_oe
);
    op_e              op;
    st_e              state;
    logic [LANES-1:0] lane_we;
    logic             rd_en;
    logic [AW-1:0]    cyc_addr;
    logic [AW-1:0]    cur_addr;
    logic             burst_on;
    logic             last_rd;

    burst_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_n    (ce_n),
        .adsp_n  (adsp_n),
        .adsc_n  (adsc_n),
        .adv_n   (adv_n),
        .bwe_n   (bwe_n),
        .op      (op),
        .lane_we (lane_we),
        .rd_en   (rd_en),
        .state   (state)
    );

    burst_addr #(.AW(AW)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .ext_addr (addr),
        .cyc_addr (cyc_addr),
        .cur_addr (cur_addr)
    );

    lane_array #(.AW(AW)) u_mem (
        .clk     (clk),
        .addr    (cyc_addr),
        .lane_we (lane_we),
        .rd_en   (rd_en),
        .wdata   (dq_in),
        .rdata   (dq_out)
    );

    assign burst_on = (state != ST_IDLE);
    assign last_rd  = (state == ST_READ);
    assign dq_oe    = !oe_n && last_rd;
endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
    parameter int AW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ce_n,
    input logic          adsp_n,
    input logic          adsc_n,
    input logic          adv_n,
    input logic [1:0]    bwe_n,
    input logic          oe_n,
    input logic [AW-1:0] addr,
    input logic          dq_oe,
    input logic          active,
    input logic          last_rd,
    input logic [AW-1:0] cur_addr
);
    AST_OE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dq_oe); // R7
    AST_DESEL_PROC: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n && !adsp_n) |=> (!active && !dq_oe)); // R2
    AST_DESEL_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n && adsp_n && !adsc_n) |=> !active); // R2
    AST_PROC_READS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !adsp_n) |=> last_rd); // R3
    AST_START_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && adsp_n && !adsc_n) |=> (cur_addr == $past(addr))); // R4
    AST_STEP_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        (active && adsp_n && adsc_n && !adv_n) |=>
        (cur_addr[AW-1:2] == $past(cur_addr[AW-1:2]) &&
         cur_addr[1:0] != $past(cur_addr[1:0]))); // R5
    AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (active && adsp_n && adsc_n && adv_n) |=> $stable(cur_addr)); // R6
    AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && adsp_n && !adsc_n && (bwe_n != 2'b11)) |=> !dq_oe); // R8
    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && adsp_n && adsc_n) |=> !active); // R1
endmodule

bind burst_sram burst_sram_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n     (ce_n),
    .adsp_n   (adsp_n),
    .adsc_n   (adsc_n),
    .adv_n    (adv_n),
    .bwe_n    (bwe_n),
    .oe_n     (oe_n),
    .addr     (addr),
    .dq_oe    (dq_oe),
    .active   (burst_on),
    .last_rd  (last_rd),
    .cur_addr (cur_addr)
);

// File: tb/sim_burst_sram.sv
`timescale 1ns/1ps
module sim_burst_sram;
    localparam int AW = 10;
    localparam int NV = 20;

    typedef struct packed {
        logic        ce_n;
        logic        adsp_n;
        logic        adsc_n;
        logic        adv_n;
        logic [1:0]  bwe_n;
        logic        oe_n;
        logic [9:0]  addr;
        logic [17:0] din;
        logic        chk_data;
        logic        exp_oe;
        logic [17:0] exp_data;
        logic [3:0]  req;
    } vec_t;

    // ce, adsp, adsc, adv, bwe, oe, addr, din, chk, exp_oe, exp_data, req
    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b1,1'b0,1'b1,2'b00,1'b1,10'h105,18'h11111,1'b0,1'b0,18'h0,4'd4},     // R4 write start
        '{1'b0,1'b1,1'b1,1'b0,2'b00,1'b1,10'h000,18'h22222,1'b0,1'b0,18'h0,4'd5},     // R5 -> 104
        '{1'b0,1'b1,1'b1,1'b0,2'b00,1'b1,10'h000,18'h33333,1'b0,1'b0,18'h0,4'd5},     // R5 -> 107
        '{1'b0,1'b1,1'b1,1'b0,2'b00,1'b1,10'h000,18'h04444,1'b0,1'b0,18'h0,4'd5},     // R5 -> 106
        '{1'b0,1'b0,1'b1,1'b1,2'b00,1'b0,10'h105,18'h3FFFF,1'b1,1'b1,18'h11111,4'd3}, // R3 read, bwe ignored
        '{1'b0,1'b1,1'b1,1'b0,2'b11,1'b0,10'h000,18'h0,1'b1,1'b1,18'h22222,4'd5},     // R5
        '{1'b0,1'b1,1'b1,1'b1,2'b11,1'b0,10'h000,18'h0,1'b1,1'b1,18'h22222,4'd6},     // R6 hold
        '{1'b1,1'b1,1'b1,1'b0,2'b11,1'b0,10'h000,18'h0,1'b1,1'b1,18'h33333,4'd10},    // R10
        '{1'b0,1'b1,1'b1,1'b0,2'b11,1'b0,10'h000,18'h0,1'b1,1'b1,18'h04444,4'd5},     // R5
        '{1'b0,1'b1,1'b1,1'b0,2'b11,1'b0,10'h000,18'h0,1'b1,1'b1,18'h11111,4'd5},     // R5 wrap
        '{1'b0,1'b1,1'b1,1'b0,2'b11,1'b1,10'h000,18'h0,1'b0,1'b0,18'h0,4'd7},         // R7
        '{1'b1,1'b1,1'b0,1'b1,2'b11,1'b0,10'h000,18'h0,1'b0,1'b0,18'h0,4'd2},         // R2
        '{1'b0,1'b1,1'b1,1'b0,2'b00,1'b0,10'h000,18'h3FFFF,1'b0,1'b0,18'h0,4'd1},     // R1 idle step
        '{1'b0,1'b1,1'b0,1'b1,2'b11,1'b0,10'h104,18'h0,1'b1,1'b1,18'h22222,4'd4},     // R4 read start
        '{1'b1,1'b1,1'b1,1'b1,2'b10,1'b0,10'h000,18'h3FFFF,1'b0,1'b0,18'h0,4'd8},     // R8 hold write
        '{1'b0,1'b1,1'b1,1'b1,2'b11,1'b0,10'h000,18'h0,1'b1,1'b1,18'h223FF,4'd9},     // R9 lower lane
        '{1'b0,1'b0,1'b1,1'b1,2'b00,1'b0,10'h106,18'h0,1'b1,1'b1,18'h04444,4'd3},     // R3
        '{1'b1,1'b0,1'b1,1'b1,2'b11,1'b0,10'h000,18'h0,1'b0,1'b0,18'h0,4'd2},         // R2
        '{1'b0,1'b1,1'b0,1'b1,2'b01,1'b1,10'h107,18'h0,1'b0,1'b0,18'h0,4'd9},         // R9 upper lane
        '{1'b0,1'b1,1'b0,1'b1,2'b11,1'b0,10'h107,18'h0,1'b1,1'b1,18'h00133,4'd1}      // R1 R9 readback
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, adsp_n = 1'b1, adsc_n = 1'b1, adv_n = 1'b1, oe_n = 1'b1;
    logic [1:0]  bwe_n = 2'b11;
    logic [9:0]  addr = '0;
    logic [17:0] dq_in = '0;
    logic [17:0] dq_out;
    logic        dq_oe;
    int          errors = 0;
    int          checks = 0;

    always #2.5 clk = ~clk;

    burst_sram #(.AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .adsp_n(adsp_n), .adsc_n(adsc_n),
        .adv_n(adv_n), .bwe_n(bwe_n), .oe_n(oe_n), .addr(addr), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    task automatic check(input bit ok, input string req, input logic [17:0] act, input logic [17:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(dq_oe == 1'b0, "R1 reset oe", {17'd0, dq_oe}, 18'd0);
        @(negedge clk) rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            ce_n = VEC[i].ce_n; adsp_n = VEC[i].adsp_n; adsc_n = VEC[i].adsc_n;
            adv_n = VEC[i].adv_n; bwe_n = VEC[i].bwe_n; oe_n = VEC[i].oe_n;
            addr = VEC[i].addr; dq_in = VEC[i].din;
            @(posedge clk);
            #1;
            check(dq_oe == VEC[i].exp_oe, $sformatf("R%0d vec%0d oe", VEC[i].req, i),
                  {17'd0, dq_oe}, {17'd0, VEC[i].exp_oe});
            if (VEC[i].chk_data)
                check(dq_out == VEC[i].exp_data, $sformatf("R%0d vec%0d data", VEC[i].req, i),
                      dq_out, VEC[i].exp_data);
        end

        // R7: output enable acts between edges
        @(negedge clk);
        ce_n = 1'b0; adsp_n = 1'b1; adsc_n = 1'b1; adv_n = 1'b1; bwe_n = 2'b11;
        oe_n = 1'b1;
        #0.5;
        check(dq_oe == 1'b0, "R7 async off", {17'd0, dq_oe}, 18'd0);
        oe_n = 1'b0;
        #0.5;
        check(dq_oe == 1'b1, "R7 async on", {17'd0, dq_oe}, 18'd1);
        check(dq_out == 18'h00133, "R7 data held", dq_out, 18'h00133);

        // R1: reset closes an open burst; a later step is ignored
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        adv_n = 1'b0;
        @(posedge clk);
        #1;
        check(dq_oe == 1'b0, "R1 step after reset", {17'd0, dq_oe}, 18'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule